// File: doc/BRIEF.md
# Two-Level Port Address Bridge

This block lets a CPU with only a handful of direct I/O select codes reach a 256-entry port space on an external peripheral bus, while the CPU keeps its memory on its own card. Software first runs an output operation on the "address" select code. That stores an 8-bit port number in a latch. It then runs an output or input operation on the "transfer" select code. That starts one bus I/O cycle: the latched number drives the low eight address lines, and the I/O-request strobe is asserted together with the write strobe or the read strobe.

A small sequencer carries out the work. It has four states. `ST_IDLE` waits for a CPU operation. `ST_WR` and `ST_RD` hold the bus strobes low for `STROBE_CYC` clocks. `ST_DONE` raises `cpu_ready` and waits until the CPU drops its operation strobe. The named transitions are:

- IDLE→DONE on an address load.
- IDLE→WR on an output to the transfer code.
- IDLE→RD on an input from the transfer code.
- WR/RD→DONE when the strobe window ends.
- DONE→IDLE when the CPU releases its operation.

Read data is captured in the last strobe cycle. It reaches the CPU data lines only while the transfer select code and the input strobe are both present. The latch keeps its value, so several accesses to the same port need only one load.

Top module: `tlpb_bridge`

## Requirements
- R1: After reset the port latch holds 0, `cpu_ready` is 0, and `bus_iorq_n`, `bus_rd_n`, `bus_wr_n` and `bus_mreq_n` are all high.
- R2: An output operation with `cpu_sel == SEL_ADDR` (default 1) stores `cpu_dout` in the port latch, raises `cpu_ready`, and asserts no bus strobe.
- R3: An output operation with `cpu_sel == SEL_XFER` (default 2) drives `bus_iorq_n` and `bus_wr_n` low for exactly `STROBE_CYC` clocks, keeps `bus_rd_n` high, and presents the CPU byte on `bus_dout`.
- R4: An input operation with `cpu_sel == SEL_XFER` drives `bus_iorq_n` and `bus_rd_n` low for exactly `STROBE_CYC` clocks, keeps `bus_wr_n` high, and returns the `bus_din` value sampled in the last strobe cycle on `cpu_din` once `cpu_ready` is 1.
- R5: While `bus_iorq_n` is low, `bus_addr[7:0]` equals the latched port number, `bus_addr[15:8]` is 0, and the address does not change.
- R6: `bus_mreq_n` is never driven low.
- R7: The latch keeps its value across any number of transfers until the next address load.
- R8: `cpu_din` is 0 unless `cpu_sel == SEL_XFER` and `cpu_inp` is 1.
- R9: An input operation on the address code, and any operation on a code that is neither the address code nor the transfer code, start no bus cycle and leave the latch unchanged.
- R10: A CPU operation held after `cpu_ready` rises starts no second bus cycle. A new operation is accepted only after both `cpu_out` and `cpu_inp` have been low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_sel | input | SEL_W | CPU I/O select code |
| cpu_out | input | 1 | CPU output operation active |
| cpu_inp | input | 1 | CPU input operation active |
| cpu_dout | input | DATA_W | Data from the CPU |
| cpu_din | output | DATA_W | Data to the CPU (0 when not a transfer read) |
| cpu_ready | output | 1 | Operation finished |
| bus_addr | output | ADDR_W | External address lines |
| bus_dout | output | DATA_W | External write data |
| bus_din | input | DATA_W | External read data |
| bus_mreq_n | output | 1 | Memory request, active low, held inactive |
| bus_iorq_n | output | 1 | I/O request, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |

## Verification
The bench sets `STROBE_CYC` to 3, so the strobe counter passes through several values. Strobe-length and address-stability checks then span more than one clock. It keeps the select codes at 1 (address) and 2 (transfer), which leaves codes 0 and 3 to 7 free to probe as ignored codes. With an 8-bit port and 16-bit address, port 0xFF and the zeroed upper address byte are both visible at the pins.

// File: rtl/tlpb_pkg.sv
package tlpb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WR   = 2'd1,
        ST_RD   = 2'd2,
        ST_DONE = 2'd3
    } tlpb_state_e;
endpackage

// File: rtl/tlpb_port_latch.sv
module tlpb_port_latch #(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic [PORT_W-1:0] d,
    output logic [PORT_W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (ld) q <= d;
    end

    // R7: the latch changes only on the clock after a load request
    p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable(q));
endmodule

// File: rtl/tlpb_seq.sv
module tlpb_seq
    import tlpb_pkg::*;
#(
    parameter int SEL_W      = 3,
    parameter int DATA_W     = 8,
    parameter int SEL_ADDR   = 1,
    parameter int SEL_XFER   = 2,
    parameter int STROBE_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  cpu_sel,
    input  logic              cpu_out,
    input  logic              cpu_inp,
    input  logic [DATA_W-1:0] cpu_dout,
    input  logic [DATA_W-1:0] bus_din,
    output logic              latch_ld,
    output logic              iorq_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic              ready,
    output logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int CNT_W = $clog2(STROBE_CYC + 1);
    localparam logic [SEL_W-1:0] CODE_ADDR = SEL_W'(SEL_ADDR);
    localparam logic [SEL_W-1:0] CODE_XFER = SEL_W'(SEL_XFER);

    tlpb_state_e state, state_nx;
    logic [CNT_W-1:0] cnt;

    wire hit_addr = cpu_out && (cpu_sel == CODE_ADDR);
    wire hit_wr   = cpu_out && (cpu_sel == CODE_XFER);
    wire hit_rd   = cpu_inp && !cpu_out && (cpu_sel == CODE_XFER);
    wire cnt_end  = (cnt == '0);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (hit_addr)    state_nx = ST_DONE;
                else if (hit_wr) state_nx = ST_WR;
                else if (hit_rd) state_nx = ST_RD;
            end
            ST_WR:   if (cnt_end) state_nx = ST_DONE;
            ST_RD:   if (cnt_end) state_nx = ST_DONE;
            ST_DONE: if (!cpu_out && !cpu_inp) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            wdata <= '0;
            rdata <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE) begin
                cnt <= CNT_W'(STROBE_CYC - 1);
                if (hit_wr) wdata <= cpu_dout;
            end else if (!cnt_end) begin
                cnt <= cnt - 1'b1;
            end
            if (state == ST_RD && cnt_end) rdata <= bus_din;
        end
    end

    always_comb begin
        iorq_n   = 1'b1;
        rd_n     = 1'b1;
        wr_n     = 1'b1;
        ready    = 1'b0;
        latch_ld = (state == ST_IDLE) && hit_addr;
        unique case (state)
            ST_IDLE: ;
            ST_WR:   begin iorq_n = 1'b0; wr_n = 1'b0; end
            ST_RD:   begin iorq_n = 1'b0; rd_n = 1'b0; end
            ST_DONE: ready = 1'b1;
            default: ;
        endcase
    end

    // strobe window length monitor
    logic [CNT_W:0] act_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       act_cnt <= '0;
        else if (!iorq_n) act_cnt <= act_cnt + 1'b1;
        else              act_cnt <= '0;
    end

    // R3 / R4: each bus cycle lasts exactly STROBE_CYC clocks
    p_strobe_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(iorq_n) |-> (act_cnt == (CNT_W+1)'(STROBE_CYC)));
    // R4: a bus cycle carries exactly one direction strobe
    p_one_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !iorq_n |-> (rd_n != wr_n));
    // R10: while the CPU holds its operation, ready stays up and no cycle starts
    p_no_retrigger_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && (cpu_out || cpu_inp)) |=> (ready && iorq_n));
endmodule

// File: rtl/tlpb_bridge.sv
module tlpb_bridge #(
    parameter int SEL_W      = 3,
    parameter int DATA_W     = 8,
    parameter int PORT_W     = 8,
    parameter int ADDR_W     = 16,
    parameter int SEL_ADDR   = 1,
    parameter int SEL_XFER   = 2,
    parameter int STROBE_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  cpu_sel,
    input  logic              cpu_out,
    input  logic              cpu_inp,
    input  logic [DATA_W-1:0] cpu_dout,
    output logic [DATA_W-1:0] cpu_din,
    output logic              cpu_ready,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    input  logic [DATA_W-1:0] bus_din,
    output logic              bus_mreq_n,
    output logic              bus_iorq_n,
    output logic              bus_rd_n,
    output logic              bus_wr_n
);
    localparam int HI_W = ADDR_W - PORT_W;
    localparam logic [SEL_W-1:0] CODE_XFER = SEL_W'(SEL_XFER);

    logic              latch_ld;
    logic [PORT_W-1:0] port_q;
    logic [DATA_W-1:0] wdata, rdata;

    tlpb_port_latch #(.PORT_W(PORT_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .ld(latch_ld),
        .d(cpu_dout[PORT_W-1:0]), .q(port_q)
    );

    tlpb_seq #(
        .SEL_W(SEL_W), .DATA_W(DATA_W), .SEL_ADDR(SEL_ADDR),
        .SEL_XFER(SEL_XFER), .STROBE_CYC(STROBE_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_out(cpu_out),
        .cpu_inp(cpu_inp), .cpu_dout(cpu_dout), .bus_din(bus_din),
        .latch_ld(latch_ld), .iorq_n(bus_iorq_n), .rd_n(bus_rd_n),
        .wr_n(bus_wr_n), .ready(cpu_ready), .wdata(wdata), .rdata(rdata)
    );

    assign bus_mreq_n = 1'b1;
    assign bus_addr   = bus_iorq_n ? '0 : {{HI_W{1'b0}}, port_q};
    assign bus_dout   = bus_wr_n ? '0 : wdata;
    assign cpu_din    = (cpu_inp && cpu_sel == CODE_XFER) ? rdata : '0;

    // R5: upper address byte is zero during a port cycle
    p_addr_hi_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_iorq_n |-> (bus_addr[ADDR_W-1:PORT_W] == '0));
    // R5: address holds steady across the strobe window
    p_addr_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_iorq_n && $past(!bus_iorq_n)) |-> $stable(bus_addr));
    // R6: a port cycle never coincides with a memory request
    p_no_mreq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_iorq_n |-> bus_mreq_n);
endmodule

// File: tb/tlpb_bridge_tb.sv
module tlpb_bridge_tb;
    localparam int STROBE_CYC = 3;
    localparam logic [2:0] S_ADDR = 3'd1;
    localparam logic [2:0] S_XFER = 3'd2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0]  cpu_sel = '0;
    logic        cpu_out = 1'b0, cpu_inp = 1'b0;
    logic [7:0]  cpu_dout = '0, bus_din = '0;
    logic [7:0]  cpu_din, bus_dout;
    logic        cpu_ready, bus_mreq_n, bus_iorq_n, bus_rd_n, bus_wr_n;
    logic [15:0] bus_addr;

    int total = 0, bad = 0;
    int n_io, n_rd, n_wr, n_mreq, n_badaddr, n_baddata;
    logic got_ready;
    logic [7:0] rd_val;

    always #5 clk = ~clk;

    tlpb_bridge #(.STROBE_CYC(STROBE_CYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_out(cpu_out),
        .cpu_inp(cpu_inp), .cpu_dout(cpu_dout), .cpu_din(cpu_din),
        .cpu_ready(cpu_ready), .bus_addr(bus_addr), .bus_dout(bus_dout),
        .bus_din(bus_din), .bus_mreq_n(bus_mreq_n), .bus_iorq_n(bus_iorq_n),
        .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // run one CPU operation; count strobe cycles and watch address/data
    task automatic op(input logic [2:0] sel, input bit is_out, input logic [7:0] d,
                      input logic [7:0] exp_port, input int extra);
        n_io = 0; n_rd = 0; n_wr = 0; n_mreq = 0; n_badaddr = 0; n_baddata = 0;
        got_ready = 1'b0; rd_val = '0;
        @(negedge clk);
        cpu_sel = sel; cpu_out = is_out; cpu_inp = !is_out; cpu_dout = d;
        for (int i = 0; i < 12 && !got_ready; i++) begin
            @(negedge clk);
            if (!bus_mreq_n) n_mreq++;
            if (!bus_iorq_n) begin
                n_io++;
                if (bus_addr != {8'h00, exp_port}) n_badaddr++;
                if (!bus_wr_n && bus_dout != d) n_baddata++;
            end
            if (!bus_rd_n) n_rd++;
            if (!bus_wr_n) n_wr++;
            if (cpu_ready) begin got_ready = 1'b1; rd_val = cpu_din; end
        end
        for (int i = 0; i < extra; i++) begin
            @(negedge clk);
            if (!bus_iorq_n) n_io++;
            if (!bus_mreq_n) n_mreq++;
        end
        cpu_out = 1'b0; cpu_inp = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk(cpu_ready == 1'b0, "R1 ready", cpu_ready, 0);
        chk({bus_iorq_n, bus_rd_n, bus_wr_n, bus_mreq_n} == 4'hF, "R1 strobes",
            {bus_iorq_n, bus_rd_n, bus_wr_n, bus_mreq_n}, 4'hF);
        op(S_XFER, 1'b1, 8'h11, 8'h00, 0);
        chk(n_badaddr == 0, "R1 latch zero after reset", n_badaddr, 0);
    endtask

    task automatic t_load(input logic [7:0] p);
        op(S_ADDR, 1'b1, p, p, 0);
        chk(got_ready, "R2 load ready", got_ready, 1);
        chk(n_io == 0 && n_rd == 0 && n_wr == 0, "R2 no strobe on load", n_io, 0);
    endtask

    task automatic t_write(input logic [7:0] p, input logic [7:0] d);
        op(S_XFER, 1'b1, d, p, 0);
        chk(n_io == STROBE_CYC && n_wr == STROBE_CYC, "R3 write length", n_wr, STROBE_CYC);
        chk(n_rd == 0, "R3 no read strobe", n_rd, 0);
        chk(n_baddata == 0, "R3 write data", n_baddata, 0);
        chk(n_badaddr == 0, "R5 address on write", n_badaddr, 0);
        chk(n_mreq == 0, "R6 mreq on write", n_mreq, 0);
    endtask

    task automatic t_read(input logic [7:0] p, input logic [7:0] d);
        bus_din = d;
        op(S_XFER, 1'b0, 8'h00, p, 0);
        chk(n_io == STROBE_CYC && n_rd == STROBE_CYC, "R4 read length", n_rd, STROBE_CYC);
        chk(n_wr == 0, "R4 no write strobe", n_wr, 0);
        chk(rd_val == d, "R4 read data", rd_val, d);
        chk(n_badaddr == 0, "R5 address on read", n_badaddr, 0);
        chk(n_mreq == 0, "R6 mreq on read", n_mreq, 0);
    endtask

    task automatic t_din_gate;
        chk(cpu_din == 8'h00, "R8 din idle", cpu_din, 0);
        @(negedge clk); cpu_sel = S_ADDR; cpu_inp = 1'b1;
        @(negedge clk);
        chk(cpu_din == 8'h00, "R8 din with address code", cpu_din, 0);
        cpu_inp = 1'b0; cpu_sel = S_XFER;
        @(negedge clk);
        chk(cpu_din == 8'h00, "R8 din without input strobe", cpu_din, 0);
        @(negedge clk); cpu_sel = 3'd0;
    endtask

    task automatic t_ignored(input logic [7:0] p);
        op(S_ADDR, 1'b0, 8'h00, p, 0);
        chk(n_io == 0 && !got_ready, "R9 input on address code", n_io, 0);
        op(3'd5, 1'b1, 8'hC3, p, 0);
        chk(n_io == 0 && !got_ready, "R9 output on unused code", n_io, 0);
        op(3'd0, 1'b0, 8'h00, p, 0);
        chk(n_io == 0 && !got_ready, "R9 input on code 0", n_io, 0);
        op(S_XFER, 1'b1, 8'h5A, p, 0);
        chk(n_badaddr == 0 && n_io == STROBE_CYC, "R9 latch unchanged", n_badaddr, 0);
    endtask

    task automatic t_hold(input logic [7:0] p);
        op(S_XFER, 1'b1, 8'h77, p, 6);
        chk(n_io == STROBE_CYC, "R10 single cycle while held", n_io, STROBE_CYC);
        op(S_XFER, 1'b1, 8'h78, p, 0);
        chk(n_io == STROBE_CYC, "R10 next op accepted", n_io, STROBE_CYC);
    endtask

    initial begin
        #1_000_000;
        bad++; total++;
        $display("FAIL watchdog act=1 exp=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load(8'h3C);
        t_write(8'h3C, 8'hA5);
        t_read(8'h3C, 8'h96);
        t_write(8'h3C, 8'h01);   // R7: no reload needed
        t_read(8'h3C, 8'h4E);    // R7: still the same port
        t_load(8'hFF);
        t_write(8'hFF, 8'hFF);
        t_read(8'hFF, 8'h00);
        t_load(8'h00);
        t_read(8'h00, 8'hFF);
        t_din_gate();
        t_load(8'h81);
        t_ignored(8'h81);
        t_hold(8'h81);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule